// File: doc/BRIEF.md
# Cluster Boot and Configuration Register Block

This block is the software-visible configuration window of a four-core processor cluster. It sits on a 32-bit APB register port and spans 1 KiB of address space. Three words are held in storage: a boot entry address, a general control word and a standby marker. The reset, status and clock-gating locations return fixed values. Writes to those fixed locations change nothing.

Each core owns a slot of three words, and the slots are spaced 0x40 apart. A nonzero write to the first word of a slot asks for that core to be started. The block turns such a write into a single-cycle request. The request carries the core number taken from the address, the entry address currently held in storage, and exception level 3. The request is only issued if the core is reported present. If the core is absent, the block sets a sticky error instead.

Locations that are recognised but not implemented raise a one-cycle unimplemented indication. Unknown or misaligned offsets raise a one-cycle out-of-range indication.

Top module: `cpu_cluster_cfg`

## Requirements
- R1: After reset the general control word reads 0x20, the standby marker and the entry address read 0, and boot_req_valid, unimpl_flag, range_flag and absent_err are all 0.
- R2: These locations are constant and ignore writes. Offsets 0x000 and 0x140 read 0x1. For core slot i (base 0x40+0x40*i, i = 0..3): base+0x0 reads 0x3, base+0x4 reads 0, base+0x8 reads 0x1. Offset 0x144 reads 0x10F.
- R3: The general control word (0x184), the standby marker (0x1A0) and the entry address (0x1A4) store all 32 bits written and read them back.
- R4: A full-word nonzero write to base+0x0 of a present core's slot raises boot_req_valid for exactly one cycle, the cycle after the access phase. During that cycle boot_req_core = (offset-0x40)>>6, boot_req_addr = the stored entry address, and boot_req_el = 3.
- R5: A write of zero to a core's base+0x0 produces no request.
- R6: A nonzero write to the slot of a core whose core_present bit is 0 produces no request. It sets absent_err, which then stays 1 until reset.
- R7: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0 and ignore writes. Every access to them pulses unimpl_flag for one cycle, the cycle after the access phase.
- R8: Any other offset, including any offset with paddr[1:0] != 0, reads 0 and ignores writes. Every access to such an offset pulses range_flag for one cycle, the cycle after the access phase. unimpl_flag and range_flag are never high together.
- R9: A write with pstrb != 4'b1111 completes with pslverr = 1. It changes no stored value, produces no request and raises no indication.
- R10: pready is always 1. Reads and full-word writes complete with pslverr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes, all four required for writes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Set for partial-strobe writes |
| core_present | input | 4 | One bit per core, 1 = core exists |
| boot_req_valid | output | 1 | Single-cycle start request |
| boot_req_core | output | 2 | Core to start |
| boot_req_addr | output | 32 | Start address |
| boot_req_el | output | 2 | Exception level to start in |
| unimpl_flag | output | 1 | Pulse on access to an unimplemented location |
| range_flag | output | 1 | Pulse on access to an unknown offset |
| absent_err | output | 1 | Sticky: a request named an absent core |

## Verification
The hardest case to reach from the ports is a start request whose address is not the reset value. The bench first sweeps writes across the entire window in address order, so the core slots are hit while the entry word still holds 0. It then programs a distinctive entry address and starts a core again, which shows that the request follows the stored word and not a constant.

The absent-core error is reached by tying one core_present bit low during the sweep. The bench then confirms that the error stays set through hundreds of later transfers.

Partial-strobe writes are aimed at a core slot, an unimplemented location and a stored word. This shows that the rejection suppresses every side effect.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_CLUSTER_RST,
    K_SYS_RST,
    K_CORE_RST,
    K_CORE_CTRL,
    K_CORE_STAT,
    K_CLK_GATE,
    K_GEN,
    K_STBY,
    K_ENTRY,
    K_UNIMPL
  } reg_kind_e;

  localparam int unsigned OFF_CLUSTER_RST = 32'h000;
  localparam int unsigned CORE_BASE       = 32'h040;
  localparam int unsigned STRIDE_LOG2     = 6;
  localparam int unsigned SLOT_RST        = 32'h0;
  localparam int unsigned SLOT_CTRL       = 32'h4;
  localparam int unsigned SLOT_STAT       = 32'h8;
  localparam int unsigned OFF_SYS_RST     = 32'h140;
  localparam int unsigned OFF_CLK_GATE    = 32'h144;
  localparam int unsigned OFF_GEN         = 32'h184;
  localparam int unsigned OFF_STBY        = 32'h1A0;
  localparam int unsigned OFF_ENTRY       = 32'h1A4;
  localparam int unsigned OFF_DBG         = 32'h1E4;
  localparam int unsigned OFF_CNT_CTL     = 32'h280;
  localparam int unsigned OFF_CNT_LO      = 32'h284;
  localparam int unsigned OFF_CNT_HI      = 32'h288;

  localparam logic [31:0] RD_RST_TOP    = 32'h1;
  localparam logic [31:0] RD_CORE_RST   = 32'h3;
  localparam logic [31:0] RD_CORE_CTRL  = 32'h0;
  localparam logic [31:0] RD_CORE_STAT  = 32'h1;
  localparam logic [31:0] RD_CLK_GATE   = 32'h10F;

endpackage

// File: rtl/ccfg_decode.sv
module ccfg_decode
  import ccfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NCORES = 4,
  parameter int CORE_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CORE_W-1:0] core_o
);
  localparam int unsigned CORE_END = CORE_BASE + (NCORES << STRIDE_LOG2);
  localparam int unsigned SLOT_MASK = (1 << STRIDE_LOG2) - 1;

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    kind_o = K_NONE;
    core_o = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 >= CORE_BASE && a32 < CORE_END) begin
        core_o = CORE_W'((a32 - CORE_BASE) >> STRIDE_LOG2);
        case (a32 & SLOT_MASK)
          SLOT_RST:  kind_o = K_CORE_RST;
          SLOT_CTRL: kind_o = K_CORE_CTRL;
          SLOT_STAT: kind_o = K_CORE_STAT;
          default:   kind_o = K_NONE;
        endcase
      end else begin
        case (a32)
          OFF_CLUSTER_RST: kind_o = K_CLUSTER_RST;
          OFF_SYS_RST:     kind_o = K_SYS_RST;
          OFF_CLK_GATE:    kind_o = K_CLK_GATE;
          OFF_GEN:         kind_o = K_GEN;
          OFF_STBY:        kind_o = K_STBY;
          OFF_ENTRY:       kind_o = K_ENTRY;
          OFF_DBG, OFF_CNT_CTL, OFF_CNT_LO, OFF_CNT_HI: kind_o = K_UNIMPL;
          default:         kind_o = K_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ccfg_regs.sv
module ccfg_regs
  import ccfg_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] GEN_RST = 32'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  reg_kind_e         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] gen_o,
  output logic [DATA_W-1:0] stby_o,
  output logic [DATA_W-1:0] entry_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_o   <= DATA_W'(GEN_RST);
      stby_o  <= '0;
      entry_o <= '0;
    end else if (we_i) begin
      case (kind_i)
        K_GEN:   gen_o   <= wdata_i;
        K_STBY:  stby_o  <= wdata_i;
        K_ENTRY: entry_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ccfg_bootreq.sv
module ccfg_bootreq #(
  parameter int NCORES  = 4,
  parameter int CORE_W  = 2,
  parameter int DATA_W  = 32,
  parameter int EL_W    = 2,
  parameter int BOOT_EL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [NCORES-1:0] present_i,
  input  logic [DATA_W-1:0] entry_i,
  output logic              valid_o,
  output logic [CORE_W-1:0] core_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [EL_W-1:0]   el_o,
  output logic              absent_err_o
);
  logic [NCORES-1:0] hit;
  logic              core_ok;

  for (genvar g = 0; g < NCORES; g++) begin : g_sel
    assign hit[g] = (core_i == CORE_W'(g)) && present_i[g];
  end
  assign core_ok = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o      <= 1'b0;
      core_o       <= '0;
      addr_o       <= '0;
      el_o         <= '0;
      absent_err_o <= 1'b0;
    end else begin
      valid_o <= fire_i && core_ok;
      if (fire_i && core_ok) begin
        core_o <= core_i;
        addr_o <= entry_i;
        el_o   <= EL_W'(BOOT_EL);
      end
      if (fire_i && !core_ok) absent_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cpu_cluster_cfg.sv
module cpu_cluster_cfg
  import ccfg_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          DATA_W  = 32,
  parameter int          NCORES  = 4,
  parameter int          EL_W    = 2,
  parameter int          BOOT_EL = 3,
  parameter logic [31:0] GEN_RST = 32'h20,
  localparam int         CORE_W  = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int         STRB_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NCORES-1:0] core_present,
  output logic              boot_req_valid,
  output logic [CORE_W-1:0] boot_req_core,
  output logic [DATA_W-1:0] boot_req_addr,
  output logic [EL_W-1:0]   boot_req_el,
  output logic              unimpl_flag,
  output logic              range_flag,
  output logic              absent_err
);
  reg_kind_e         kind;
  logic [CORE_W-1:0] core_idx;
  logic [DATA_W-1:0] gen_q, stby_q, entry_q, rd_mux;
  logic              setup_ph, access_ph, bad_wr, wr_ok, fire;

  ccfg_decode #(.ADDR_W(ADDR_W), .NCORES(NCORES), .CORE_W(CORE_W)) u_dec (
    .addr_i(paddr), .kind_o(kind), .core_o(core_idx)
  );

  assign setup_ph  = psel && !penable;
  assign access_ph = psel && penable;
  assign bad_wr    = pwrite && !(&pstrb);
  assign wr_ok     = access_ph && pwrite && !bad_wr;
  assign fire      = wr_ok && (kind == K_CORE_RST) && (|pwdata);
  assign pready    = 1'b1;

  ccfg_regs #(.DATA_W(DATA_W), .GEN_RST(GEN_RST)) u_regs (
    .clk(clk), .rst(rst), .we_i(wr_ok), .kind_i(kind), .wdata_i(pwdata),
    .gen_o(gen_q), .stby_o(stby_q), .entry_o(entry_q)
  );

  ccfg_bootreq #(
    .NCORES(NCORES), .CORE_W(CORE_W), .DATA_W(DATA_W),
    .EL_W(EL_W), .BOOT_EL(BOOT_EL)
  ) u_boot (
    .clk(clk), .rst(rst), .fire_i(fire), .core_i(core_idx),
    .present_i(core_present), .entry_i(entry_q),
    .valid_o(boot_req_valid), .core_o(boot_req_core), .addr_o(boot_req_addr),
    .el_o(boot_req_el), .absent_err_o(absent_err)
  );

  always_comb begin
    case (kind)
      K_CLUSTER_RST, K_SYS_RST: rd_mux = DATA_W'(RD_RST_TOP);
      K_CORE_RST:               rd_mux = DATA_W'(RD_CORE_RST);
      K_CORE_CTRL:              rd_mux = DATA_W'(RD_CORE_CTRL);
      K_CORE_STAT:              rd_mux = DATA_W'(RD_CORE_STAT);
      K_CLK_GATE:               rd_mux = DATA_W'(RD_CLK_GATE);
      K_GEN:                    rd_mux = gen_q;
      K_STBY:                   rd_mux = stby_q;
      K_ENTRY:                  rd_mux = entry_q;
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata      <= '0;
      pslverr     <= 1'b0;
      unimpl_flag <= 1'b0;
      range_flag  <= 1'b0;
    end else begin
      if (setup_ph) begin
        prdata  <= pwrite ? '0 : rd_mux;
        pslverr <= bad_wr;
      end
      unimpl_flag <= access_ph && !bad_wr && (kind == K_UNIMPL);
      range_flag  <= access_ph && !bad_wr && (kind == K_NONE);
    end
  end
endmodule

// File: rtl/ccfg_checker.sv
module ccfg_checker #(
  parameter int NCORES = 4,
  parameter int CORE_W = 2,
  parameter int EL_W   = 2,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [STRB_W-1:0] pstrb,
  input logic              pslverr,
  input logic [NCORES-1:0] core_present,
  input logic              boot_req_valid,
  input logic [CORE_W-1:0] boot_req_core,
  input logic [EL_W-1:0]   boot_req_el,
  input logic              unimpl_flag,
  input logic              range_flag,
  input logic              absent_err
);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    boot_req_valid |=> !boot_req_valid);

  p_level_three_r4: assert property (@(posedge clk) disable iff (rst)
    boot_req_valid |-> boot_req_el == EL_W'(3));

  p_present_core_r6: assert property (@(posedge clk) disable iff (rst)
    boot_req_valid |-> ((($past(core_present) >> boot_req_core) & NCORES'(1)) != '0));

  p_sticky_absent_r6: assert property (@(posedge clk) disable iff (rst)
    absent_err |=> absent_err);

  p_partial_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && !(&pstrb)) |=>
      (!boot_req_valid && !unimpl_flag && !range_flag));

  p_flags_apart_r8: assert property (@(posedge clk) disable iff (rst)
    !(unimpl_flag && range_flag));

  p_read_no_err_r10: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite) |-> !pslverr);
endmodule

bind cpu_cluster_cfg ccfg_checker #(
  .NCORES(NCORES), .CORE_W(CORE_W), .EL_W(EL_W), .STRB_W(STRB_W)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pstrb(pstrb), .pslverr(pslverr), .core_present(core_present),
  .boot_req_valid(boot_req_valid), .boot_req_core(boot_req_core),
  .boot_req_el(boot_req_el), .unimpl_flag(unimpl_flag),
  .range_flag(range_flag), .absent_err(absent_err)
);

// File: tb/cpu_cluster_cfg_test.sv
module cpu_cluster_cfg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [3:0]  core_present = 4'b1011;
  logic        boot_req_valid;
  logic [1:0]  boot_req_core;
  logic [31:0] boot_req_addr;
  logic [1:0]  boot_req_el;
  logic        unimpl_flag, range_flag, absent_err;

  int checks = 0;
  int errors = 0;

  // model state
  logic [31:0] m_gen = 32'h20, m_stby = 0, m_entry = 0;
  logic        m_absent = 0;

  // observations
  logic [31:0] o_rdata, o_addr;
  logic        o_err, o_ready, o_valid, o_next, o_unimpl, o_range, o_absent;
  logic [1:0]  o_core, o_el;

  always #2.5 clk = ~clk;

  cpu_cluster_cfg uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .core_present(core_present),
    .boot_req_valid(boot_req_valid), .boot_req_core(boot_req_core),
    .boot_req_addr(boot_req_addr), .boot_req_el(boot_req_el),
    .unimpl_flag(unimpl_flag), .range_flag(range_flag), .absent_err(absent_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // class codes: 0 unknown,1 top rst,3 core rst,4 core ctrl,5 core stat,
  // 6 clk gate,7 gen,8 stby,9 entry,10 unimplemented
  function automatic int cls_of(int a);
    if (a % 4 != 0) return 0;
    if (a >= 64 && a < 320) begin
      case (a % 64)
        0: return 3;
        4: return 4;
        8: return 5;
        default: return 0;
      endcase
    end
    case (a)
      0, 320: return 1;
      324: return 6;
      388: return 7;
      416: return 8;
      420: return 9;
      484, 640, 644, 648: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int c);
    case (c)
      1: return 32'h1;
      3: return 32'h3;
      5: return 32'h1;
      6: return 32'h10F;
      7: return m_gen;
      8: return m_stby;
      9: return m_entry;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(int c);
    case (c)
      0: return "R8";
      7, 8, 9: return "R3";
      10: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic xfer(input int a, input bit wr, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    psel = 1; penable = 0; paddr = 10'(a); pwrite = wr; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1;
    o_err = pslverr; o_rdata = prdata; o_ready = pready;
    @(negedge clk);
    psel = 0; penable = 0;
    o_valid = boot_req_valid; o_core = boot_req_core; o_addr = boot_req_addr;
    o_el = boot_req_el; o_unimpl = unimpl_flag; o_range = range_flag; o_absent = absent_err;
    @(negedge clk);
    o_next = boot_req_valid;
  endtask

  task automatic rd_check(input int a);
    int c = cls_of(a);
    xfer(a, 1'b0, 32'h0, 4'h0);
    chk(o_rdata == exp_rd(c), req_of(c), $sformatf("read @%0h", a), o_rdata, exp_rd(c));
    chk(!o_err && o_ready, "R10", "read completion", {30'd0, o_err, o_ready}, 32'h1);
    chk(o_unimpl == (c == 10), "R7", $sformatf("unimpl flag @%0h", a), 32'(o_unimpl), 32'(c == 10));
    chk(o_range == (c == 0), "R8", $sformatf("range flag @%0h", a), 32'(o_range), 32'(c == 0));
  endtask

  task automatic wr_check(input int a, input logic [31:0] d);
    int  c = cls_of(a);
    int  core = (a - 64) >> 6;
    bit  req = (c == 3) && (d != 0);
    bit  pres = req && core_present[core];
    logic [31:0] ent = m_entry;
    xfer(a, 1'b1, d, 4'hF);
    if (req && !pres) m_absent = 1;
    if (c == 7) m_gen = d;
    if (c == 8) m_stby = d;
    if (c == 9) m_entry = d;
    chk(!o_err, "R10", $sformatf("write err @%0h", a), 32'(o_err), 0);
    chk(o_valid == pres, (req && !pres) ? "R6" : (c == 3 ? "R5" : "R4"),
        $sformatf("request @%0h", a), 32'(o_valid), 32'(pres));
    if (pres) begin
      chk(o_core == 2'(core), "R4", "request core", 32'(o_core), 32'(core));
      chk(o_addr == ent, "R4", "request addr", o_addr, ent);
      chk(o_el == 2'd3, "R4", "request level", 32'(o_el), 3);
    end
    chk(!o_next, "R4", "request width", 32'(o_next), 0);
    chk(o_absent == m_absent, "R6", $sformatf("absent err @%0h", a), 32'(o_absent), 32'(m_absent));
    chk(o_unimpl == (c == 10), "R7", "unimpl flag on write", 32'(o_unimpl), 32'(c == 10));
    chk(o_range == (c == 0), "R8", "range flag on write", 32'(o_range), 32'(c == 0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!boot_req_valid && !absent_err && !unimpl_flag && !range_flag, "R1",
        "outputs after reset", {28'd0, boot_req_valid, absent_err, unimpl_flag, range_flag}, 0);
    rd_check(388); rd_check(416); rd_check(420);

    // full read sweep over reset contents
    for (int a = 0; a < 1024; a += 4) rd_check(a);

    // full write sweep, then read back everything
    for (int a = 0; a < 1024; a += 4) wr_check(a, 32'h5A00_0001 + 32'(a) * 32'h10001);
    for (int a = 0; a < 1024; a += 4) rd_check(a);

    // R5: zero write to a present core
    wr_check(128, 32'h0);

    // R4: start request carries programmed entry address
    wr_check(420, 32'h8000_1234);
    wr_check(256, 32'h1);
    wr_check(64, 32'hFFFF_FFFF);

    // R9: partial strobes
    xfer(388, 1'b1, 32'hDEAD_BEEF, 4'h7);
    chk(o_err, "R9", "partial write err", 32'(o_err), 1);
    rd_check(388);
    xfer(64, 1'b1, 32'h1, 4'h1);
    chk(o_err && !o_valid, "R9", "partial core write", {30'd0, o_err, o_valid}, 32'h2);
    xfer(484, 1'b1, 32'h1, 4'hE);
    chk(!o_unimpl && !o_range, "R9", "partial write flags", {30'd0, o_unimpl, o_range}, 0);

    // R8: misaligned offsets
    for (int a = 417; a < 424; a++) if (a % 4 != 0) rd_check(a);
    wr_check(421, 32'h77);
    rd_check(420);

    chk(absent_err, "R6", "absent err still held", 32'(absent_err), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule